// File: doc/BRIEF.md
# Bridge Configuration Register File

This block holds the configuration registers of a bridge-type function: a 64-byte type-1 header, followed at byte offset 0x40 by an optional 60-byte PCI Express capability. A host agent reaches the registers through a single request port. Each request carries a byte address, an access size of 1, 2 or 4 bytes, a write flag and write data. One cycle later the port returns a response with read data and an error flag.

Every bit of every dword has one attribute: read-only, read-write or write-1-to-clear. A bit with none of these is reserved and always reads as zero. Partial writes touch only the addressed byte lanes. Within those lanes, read-write bits take the new data and write-1-to-clear bits are cleared wherever the data carries a one. Every other bit keeps its value.

Logic on the hardware side reports events through a set port. The port names one dword and a bit vector, and only the write-1-to-clear bits of that dword are set. Two elaboration parameters select the variant: one removes the capability region, and one removes I/O forwarding.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset the registers read as follows: dword 0x00 holds parameter DEV_VEN_ID; dword 0x08 holds {24'h060400, REV_ID}; dword 0x0C holds 0x0001_0010 (header type 1 in bits 23:16, cache line size 0x10 in bits 7:0); dword 0x04 reads 0x0010_0000 (capability-list status bit 20 set); dword 0x34 holds 0x40; dword 0x40 holds 0x0042_0010 (capability ID 0x10, next pointer 0, root-port type 4 in bits 23:20, version 2).
- R2: Read data is the stored dword ANDed with the union of its read-only, read-write and write-1-to-clear masks. For example, after all ones are written to dword 0x48 it reads 0x0000_7FFF, and dword 0x5C reads 0x0000_001F.
- R3: The dword index is addr[7:2] and the byte offset is addr[1:0]. A size-1 read returns bits [8*off+7 : 8*off]. A size-2 read returns the 16 bits starting at bit 8*off. A size-4 read ignores the offset.
- R4: A request whose size is 0, 3, 5, 6 or 7 returns rsp_err=1 and zero data, and it changes no register.
- R5: The write lane mask is 0xFF<<(8*off) for size 1, 0xFFFF<<(8*off) for size 2, and all ones for size 4 (data not shifted). Bits outside the mask keep their value.
- R6: A write never changes a read-only bit.
- R7: A write-1-to-clear bit inside the lane mask is cleared when the write data bit is 1 and kept when it is 0. These bits are bits 31:27 and 24 of dwords 0x04 and 0x1C, bits 19:16 of 0x48, bits 31:30 of 0x50, bits 24 and 20:16 of 0x58, bit 16 of 0x60, and bits 31 and 21 of 0x70.
- R8: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R9: When hw_set_en is high, hw_set_bits is ORed into the write-1-to-clear bits of dword index hw_set_dw only. Other bits of that dword and all other dwords are unchanged, and an index beyond the last implemented dword does nothing.
- R10: The read-write fields are as follows. Dword 0x04 has command bits 0, 1, 2, 6 and 8. Dword 0x18 has bits 23:0. Dword 0x1C has bits 15:12 and 7:4. Dwords 0x20 and 0x24 have bits 31:20 and 15:4. Dwords 0x28, 0x2C and 0x30 are fully read-write. Dword 0x3C has bits 7:0 plus 16, 17, 18, 19 and 22.
- R11: With IO_FWD=0, command bit 0 and bits 15:0 of dword 0x1C are read-only zero, and dword 0x30 is read-only zero.
- R12: Addresses from 0x7C to 0xFF (from 0x40 when HAS_PCIE=0) read as zero, and writes to them change nothing.
- R13: rsp_valid is high in exactly the cycle after each cycle with req_valid high. A write response carries zero data and rsp_err=0 unless the size is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address in configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, right-aligned |
| hw_set_en | input | 1 | Hardware status set strobe |
| hw_set_dw | input | 5 | Dword index targeted by the set |
| hw_set_bits | input | 32 | Bits to set (write-1-to-clear bits only) |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Illegal access size |

## Verification
On every cycle, the assertions check four things: read-only bits never move, a hardware set always lands even against a clear, cleared status bits are zero after a write, and lanes outside the mask are left alone. They also check that responses follow requests by one cycle and that illegal sizes and unmapped reads return zero. What only the bench scenarios can show is that each attribute map holds the right bit positions, which the reset values are, how sub-dword reads are extracted, and how the I/O-less variant behaves. A behavioural model tracks all of this and is compared on every clock.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int HDR_DWORDS = 16;
    localparam int CAP_DWORDS = 15;
    localparam int MAX_DWORDS = HDR_DWORDS + CAP_DWORDS;
    localparam int IDX_W      = $clog2(MAX_DWORDS);

    typedef struct packed {
        logic [DATA_W-1:0] ro;
        logic [DATA_W-1:0] rw;
        logic [DATA_W-1:0] w1c;
    } bit_attr_t;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd1,
        SZ_HALF = 3'd2,
        SZ_WORD = 3'd4
    } acc_size_e;

    function automatic bit_attr_t attr_of(int idx, bit has_pcie, bit io_fwd);
        bit_attr_t a;
        a = '0;
        case (idx)
            0, 2, 4, 5, 14: a.ro = 32'hFFFF_FFFF;
            1: begin
                a.rw  = 32'h0000_0147;
                a.ro  = has_pcie ? 32'h0010_0000 : 32'h0610_0000;
                a.w1c = 32'hF900_0000;
                if (!io_fwd) begin
                    a.rw[0] = 1'b0;
                    a.ro[0] = 1'b1;
                end
            end
            3:  a.ro = has_pcie ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
            6: begin
                a.rw = 32'h00FF_FFFF;
                a.ro = has_pcie ? 32'h0000_0000 : 32'hFF00_0000;
            end
            7: begin
                a.rw  = io_fwd ? 32'h0000_F0F0 : 32'h0000_0000;
                a.ro  = io_fwd ? 32'h0000_0F0F : 32'h0000_FFFF;
                a.w1c = 32'hF900_0000;
            end
            8, 9: begin
                a.rw = 32'hFFF0_FFF0;
                a.ro = 32'h000F_000F;
            end
            10, 11: a.rw = 32'hFFFF_FFFF;
            12: begin
                a.rw = io_fwd ? 32'hFFFF_FFFF : 32'h0000_0000;
                a.ro = io_fwd ? 32'h0000_0000 : 32'hFFFF_FFFF;
            end
            13: a.ro = 32'h0000_00FF;
            15: begin
                a.rw = has_pcie ? 32'h004F_00FF : 32'h006F_00FF;
                a.ro = 32'h0000_FF00;
            end
            16: a.ro = 32'h7FFF_FFFF;
            17: a.ro = 32'h0000_803F;
            18: begin
                a.rw  = 32'h0000_7FFF;
                a.w1c = 32'h000F_0000;
                a.ro  = 32'h0030_0000;
            end
            19: a.ro = 32'hFF7B_FFFF;
            20: begin
                a.rw  = 32'h0000_CEFB;
                a.ro  = 32'h3FFF_0000;
                a.w1c = 32'hC000_0000;
            end
            21: a.ro = 32'hFFFF_FFFF;
            22: begin
                a.rw  = 32'h0000_7FFF;
                a.w1c = 32'h011F_0000;
                a.ro  = 32'h00E0_0000;
            end
            23: begin
                a.rw = 32'h0000_001F;
                a.ro = 32'h0001_0000;
            end
            24: begin
                a.ro  = 32'h0002_FFFF;
                a.w1c = 32'h0001_0000;
            end
            25: a.ro = 32'h80FF_FFFF;
            26: a.rw = 32'h0000_F7FF;
            27: a.ro = 32'h81FF_FFFE;
            28: begin
                a.rw  = 32'h0000_FFFF;
                a.w1c = 32'h8020_0000;
                a.ro  = 32'h73DF_0000;
            end
            default: a = '0;
        endcase
        if (idx >= HDR_DWORDS && !has_pcie) a = '0;
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] reset_of(int idx, bit has_pcie,
                                                   logic [DATA_W-1:0] dev_ven,
                                                   logic [7:0] rev);
        case (idx)
            0:       return dev_ven;
            1:       return has_pcie ? 32'h0010_0000 : 32'h0000_0000;
            2:       return {24'h060400, rev};
            3:       return 32'h0001_0010;
            13:      return has_pcie ? 32'h0000_0040 : 32'h0000_0000;
            16:      return 32'h0042_0010;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_lane_dec.sv
module bcr_lane_dec
    import bcr_pkg::*;
(
    input  logic [1:0]        off,
    input  logic [2:0]        size,
    output logic              size_ok,
    output logic [DATA_W-1:0] bmask,
    output logic [4:0]        shamt
);
    always_comb begin
        size_ok = 1'b1;
        shamt   = {off, 3'b000};
        bmask   = '0;
        case (size)
            SZ_BYTE: bmask = 32'h0000_00FF << shamt;
            SZ_HALF: bmask = 32'h0000_FFFF << shamt;
            SZ_WORD: begin
                bmask = 32'hFFFF_FFFF;
                shamt = 5'd0;
            end
            default: begin
                size_ok = 1'b0;
                shamt   = 5'd0;
            end
        endcase
    end

    // R5
    always_comb begin
        if (size_ok) lane_nonempty_chk: assert ($countones(bmask) >= 8);
    end
endmodule

// File: rtl/bcr_dword.sv
module bcr_dword
    import bcr_pkg::*;
#(
    parameter bit_attr_t         ATTR    = '0,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] bmask,
    input  logic [DATA_W-1:0] wdata_sh,
    input  logic              hw_en,
    input  logic [DATA_W-1:0] hw_bits,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] FIXED = ~(ATTR.rw | ATTR.w1c);

    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt = (q & ~(ATTR.rw & bmask)) | (wdata_sh & ATTR.rw & bmask);
            nxt = nxt & ~(wdata_sh & ATTR.w1c & bmask);
        end
        if (hw_en) nxt = nxt | (hw_bits & ATTR.w1c);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= nxt;
    end

    // R6
    ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((q & FIXED) == (RST_VAL & FIXED)));

    // R8
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hw_en |=> ((q & $past(hw_bits & ATTR.w1c)) == $past(hw_bits & ATTR.w1c)));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hw_en) |=> ((q & $past(wdata_sh & bmask & ATTR.w1c)) == '0));

    // R5
    lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((q & ~$past(bmask) & ~ATTR.w1c) == ($past(q) & ~$past(bmask) & ~ATTR.w1c)));
endmodule

// File: rtl/bcr_rd_fmt.sv
module bcr_rd_fmt
    import bcr_pkg::*;
(
    input  logic              hit,
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] vis,
    input  logic [4:0]        shamt,
    input  logic [2:0]        size,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        masked  = hit ? (raw & vis) : '0;
        shifted = masked >> shamt;
        case (size)
            SZ_BYTE: data = {24'd0, shifted[7:0]};
            SZ_HALF: data = {16'd0, shifted[15:0]};
            SZ_WORD: data = masked;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcr_pkg::*;
#(
    parameter bit          HAS_PCIE   = 1'b1,
    parameter bit          IO_FWD     = 1'b1,
    parameter logic [31:0] DEV_VEN_ID = 32'h1A2B_3C4D,
    parameter logic [7:0]  REV_ID     = 8'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hw_set_en,
    input  logic [IDX_W-1:0]  hw_set_dw,
    input  logic [DATA_W-1:0] hw_set_bits,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);
    localparam int NDW = HAS_PCIE ? MAX_DWORDS : HDR_DWORDS;
    localparam int DWI = ADDR_W - 2;

    logic [DWI-1:0]    req_dw;
    logic              hit;
    logic              size_ok;
    logic [DATA_W-1:0] bmask;
    logic [4:0]        shamt;
    logic [DATA_W-1:0] wdata_sh;
    logic [DATA_W-1:0] raw_sel;
    logic [DATA_W-1:0] vis_sel;
    logic [DATA_W-1:0] fmt_data;
    logic [DATA_W-1:0] q   [NDW];
    logic [DATA_W-1:0] vis [NDW];
    logic [NDW-1:0]    wr_hit;
    logic [NDW-1:0]    hw_hit;

    assign req_dw   = req_addr[ADDR_W-1:2];
    assign hit      = (req_dw < DWI'(NDW));
    assign wdata_sh = req_wdata << shamt;

    bcr_lane_dec u_lane (
        .off     (req_addr[1:0]),
        .size    (req_size),
        .size_ok (size_ok),
        .bmask   (bmask),
        .shamt   (shamt)
    );

    for (genvar i = 0; i < NDW; i++) begin : g_dw
        localparam bit_attr_t A = attr_of(i, HAS_PCIE, IO_FWD);
        assign wr_hit[i] = req_valid && req_write && size_ok && (req_dw == DWI'(i));
        assign hw_hit[i] = hw_set_en && (hw_set_dw == IDX_W'(i));
        assign vis[i]    = A.ro | A.rw | A.w1c;
        bcr_dword #(
            .ATTR    (A),
            .RST_VAL (reset_of(i, HAS_PCIE, DEV_VEN_ID, REV_ID))
        ) u_reg (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_hit[i]),
            .bmask    (bmask),
            .wdata_sh (wdata_sh),
            .hw_en    (hw_hit[i]),
            .hw_bits  (hw_set_bits),
            .q        (q[i])
        );
    end

    always_comb begin
        raw_sel = '0;
        vis_sel = '0;
        for (int i = 0; i < NDW; i++) begin
            if (req_dw == DWI'(i)) begin
                raw_sel = q[i];
                vis_sel = vis[i];
            end
        end
    end

    bcr_rd_fmt u_fmt (
        .hit   (hit),
        .raw   (raw_sel),
        .vis   (vis_sel),
        .shamt (shamt),
        .size  (req_size),
        .data  (fmt_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !size_ok;
            rsp_rdata <= (req_valid && !req_write) ? fmt_data : '0;
        end
    end

    // R13
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R13
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R4
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_size inside {3'd1, 3'd2, 3'd4})) |=> (rsp_err && rsp_rdata == '0));

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (req_addr[ADDR_W-1:2] >= DWI'(NDW))) |=> (rsp_rdata == '0));
endmodule

// File: tb/bridge_cfg_regs_tb.sv
module bridge_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, hw_set_en = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0, hw_set_bits = '0;
    logic [4:0]  hw_set_dw = '0;
    logic        rsp_valid, rsp_err, nio_valid, nio_err;
    logic [31:0] rsp_rdata, nio_rdata;

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0, mon_on = 1'b0;
    logic [31:0] last_rd, last_nio;
    logic        last_err;

    always #5 clk = ~clk;

    bridge_cfg_regs u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .hw_set_en(hw_set_en), .hw_set_dw(hw_set_dw), .hw_set_bits(hw_set_bits),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

    bridge_cfg_regs #(.IO_FWD(1'b0)) u_dut_nio (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .hw_set_en(hw_set_en), .hw_set_dw(hw_set_dw), .hw_set_bits(hw_set_bits),
        .rsp_valid(nio_valid), .rsp_rdata(nio_rdata), .rsp_err(nio_err));

    // ---------------- behavioural reference model of u_dut ----------------
    logic [31:0] m_ro [31], m_rw [31], m_wc [31], m_mem [31];
    logic        exp_valid = 1'b0, exp_err = 1'b0;
    logic [31:0] exp_rdata = '0;

    task automatic set_a(int i, logic [31:0] ro, logic [31:0] rw, logic [31:0] wc, logic [31:0] rv);
        m_ro[i] = ro; m_rw[i] = rw; m_wc[i] = wc; m_mem[i] = rv;
    endtask

    task automatic model_init();
        for (int i = 0; i < 31; i++) set_a(i, 0, 0, 0, 0);
        set_a(0, 32'hFFFFFFFF, 0, 0, 32'h1A2B3C4D);
        set_a(1, 32'h00100000, 32'h00000147, 32'hF9000000, 32'h00100000);
        set_a(2, 32'hFFFFFFFF, 0, 0, 32'h06040005);
        set_a(3, 32'hFFFF00FF, 0, 0, 32'h00010010);
        set_a(4, 32'hFFFFFFFF, 0, 0, 0);
        set_a(5, 32'hFFFFFFFF, 0, 0, 0);
        set_a(6, 0, 32'h00FFFFFF, 0, 0);
        set_a(7, 32'h00000F0F, 32'h0000F0F0, 32'hF9000000, 0);
        set_a(8, 32'h000F000F, 32'hFFF0FFF0, 0, 0);
        set_a(9, 32'h000F000F, 32'hFFF0FFF0, 0, 0);
        set_a(10, 0, 32'hFFFFFFFF, 0, 0);
        set_a(11, 0, 32'hFFFFFFFF, 0, 0);
        set_a(12, 0, 32'hFFFFFFFF, 0, 0);
        set_a(13, 32'h000000FF, 0, 0, 32'h00000040);
        set_a(14, 32'hFFFFFFFF, 0, 0, 0);
        set_a(15, 32'h0000FF00, 32'h004F00FF, 0, 0);
        set_a(16, 32'h7FFFFFFF, 0, 0, 32'h00420010);
        set_a(17, 32'h0000803F, 0, 0, 0);
        set_a(18, 32'h00300000, 32'h00007FFF, 32'h000F0000, 0);
        set_a(19, 32'hFF7BFFFF, 0, 0, 0);
        set_a(20, 32'h3FFF0000, 32'h0000CEFB, 32'hC0000000, 0);
        set_a(21, 32'hFFFFFFFF, 0, 0, 0);
        set_a(22, 32'h00E00000, 32'h00007FFF, 32'h011F0000, 0);
        set_a(23, 32'h00010000, 32'h0000001F, 0, 0);
        set_a(24, 32'h0002FFFF, 0, 32'h00010000, 0);
        set_a(25, 32'h80FFFFFF, 0, 0, 0);
        set_a(26, 0, 32'h0000F7FF, 0, 0);
        set_a(27, 32'h81FFFFFE, 0, 0, 0);
        set_a(28, 32'h73DF0000, 32'h0000FFFF, 32'h80200000, 0);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_init();
            exp_valid = 1'b0; exp_err = 1'b0; exp_rdata = '0;
        end else begin
            int dw, off, sh;
            logic [31:0] v, m, d;
            bit ok;
            dw  = int'(req_addr) / 4;
            off = int'(req_addr) % 4;
            ok  = (req_size == 1) || (req_size == 2) || (req_size == 4);
            sh  = (req_size == 4) ? 0 : 8 * off;
            exp_valid = req_valid;
            exp_err   = req_valid && !ok;
            exp_rdata = '0;
            if (req_valid && ok) begin
                if (!req_write) begin
                    v = (dw < 31) ? (m_mem[dw] & (m_ro[dw] | m_rw[dw] | m_wc[dw])) : 32'h0;
                    v = v >> sh;
                    if (req_size == 1) v = v & 32'hFF;
                    if (req_size == 2) v = v & 32'hFFFF;
                    exp_rdata = v;
                end else if (dw < 31) begin
                    m = (req_size == 4) ? 32'hFFFFFFFF : (req_size == 2 ? 32'hFFFF << sh : 32'hFF << sh);
                    d = req_wdata << sh;
                    m_mem[dw] = (m_mem[dw] & ~(m_rw[dw] & m)) | (d & m_rw[dw] & m);
                    m_mem[dw] = m_mem[dw] & ~(d & m_wc[dw] & m);
                end
            end
            if (hw_set_en && hw_set_dw < 31) m_mem[hw_set_dw] = m_mem[hw_set_dw] | (hw_set_bits & m_wc[hw_set_dw]);
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (mon_on && !done) begin
            nchk++;
            if (rsp_valid !== exp_valid || (exp_valid && (rsp_rdata !== exp_rdata || rsp_err !== exp_err))) begin
                nfail++;
                $display("FAIL R13 model: valid=%b data=%h err=%b expected valid=%b data=%h err=%b",
                         rsp_valid, rsp_rdata, rsp_err, exp_valid, exp_rdata, exp_err);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL R13 watchdog: cycles=%0d expected below 5000", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic acc(input logic [7:0] a, input logic [2:0] sz, input logic wr, input logic [31:0] wd,
                       input logic he, input logic [4:0] hd, input logic [31:0] hb, input logic rq);
        @(negedge clk);
        req_valid = rq; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        hw_set_en = he; hw_set_dw = hd; hw_set_bits = hb;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_set_en = 1'b0;
        last_rd = rsp_rdata; last_err = rsp_err; last_nio = nio_rdata;
    endtask

    task automatic rd(input logic [7:0] a, input logic [2:0] sz);
        acc(a, sz, 1'b0, 32'h0, 1'b0, 5'd0, 32'h0, 1'b1);
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        acc(a, sz, 1'b1, d, 1'b0, 5'd0, 32'h0, 1'b1);
    endtask

    task automatic hw(input logic [4:0] dw, input logic [31:0] b);
        acc(8'h0, 3'd4, 1'b0, 32'h0, 1'b1, dw, b, 1'b0);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        mon_on = 1'b1;
        @(negedge clk);
        chk("R13 idle after reset", {31'd0, rsp_valid}, 32'd0);

        // R1 reset values
        rd(8'h00, 4); chk("R1 id dword", last_rd, 32'h1A2B3C4D);
        rd(8'h08, 4); chk("R1 class/rev", last_rd, 32'h06040005);
        rd(8'h0C, 4); chk("R1 header type/cache line", last_rd, 32'h00010010);
        rd(8'h04, 4); chk("R1 status cap bit", last_rd, 32'h00100000);
        rd(8'h34, 4); chk("R1 cap pointer", last_rd, 32'h00000040);
        rd(8'h40, 4); chk("R1 capability header", last_rd, 32'h00420010);

        // R3 sub-dword reads
        rd(8'h0B, 1); chk("R3 byte read", last_rd, 32'h06);
        rd(8'h0A, 2); chk("R3 half read", last_rd, 32'h0604);
        rd(8'h42, 2); chk("R3 cap field read", last_rd, 32'h0042);
        rd(8'h0E, 1); chk("R3 header type byte", last_rd, 32'h01);
        rd(8'h0B, 4); chk("R3 word ignores offset", last_rd, 32'h06040005);

        // R13 write response
        wr(8'h3C, 4, 32'hFFFFFFFF);
        chk("R13 write rsp data", last_rd, 32'h0);
        chk("R13 write rsp err", {31'd0, last_err}, 32'h0);
        rd(8'h3C, 4); chk("R10 bridge control", last_rd, 32'h004F00FF);

        // R10 command
        wr(8'h04, 4, 32'hFFFFFFFF);
        rd(8'h04, 4); chk("R10 command rw bits", last_rd, 32'h00100147);

        // R2 reserved bits
        wr(8'h48, 4, 32'hFFFFFFFF);
        rd(8'h48, 4); chk("R2 device control reserved", last_rd, 32'h00007FFF);
        wr(8'h5C, 4, 32'hFFFFFFFF);
        rd(8'h5C, 4); chk("R2 root control reserved", last_rd, 32'h0000001F);

        // R5 lane writes
        wr(8'h19, 1, 32'h000000AB);
        rd(8'h18, 4); chk("R5 byte lane write", last_rd, 32'h0000AB00);
        wr(8'h1A, 2, 32'h00001234);
        rd(8'h18, 4); chk("R5 half lane write", last_rd, 32'h0034AB00);

        // R6 read-only bits
        wr(8'h20, 4, 32'hFFFFFFFF);
        rd(8'h20, 4); chk("R6 memory window ro nibbles", last_rd, 32'hFFF0FFF0);
        wr(8'h08, 4, 32'h0);
        rd(8'h08, 4); chk("R6 class unchanged", last_rd, 32'h06040005);
        wr(8'h00, 2, 32'h0);
        rd(8'h00, 4); chk("R6 id unchanged", last_rd, 32'h1A2B3C4D);

        // R9 hardware set
        hw(5'd7, 32'hFFFFFFFF);
        rd(8'h1C, 4); chk("R9 set only w1c bits", last_rd, 32'hF9000000);
        hw(5'd0, 32'hFFFFFFFF);
        rd(8'h00, 4); chk("R9 set on ro dword", last_rd, 32'h1A2B3C4D);
        hw(5'd31, 32'hFFFFFFFF);
        rd(8'h1C, 4); chk("R9 out-of-range index", last_rd, 32'hF9000000);

        // R7 write-1-to-clear
        wr(8'h1E, 2, 32'h00008000);
        rd(8'h1C, 4); chk("R7 clear bit 31", last_rd, 32'h79000000);
        wr(8'h1C, 1, 32'h000000FF);
        rd(8'h1C, 4); chk("R7 lane outside w1c", last_rd, 32'h790000F0);
        wr(8'h1F, 1, 32'h00000000);
        rd(8'h1C, 4); chk("R7 zero keeps", last_rd, 32'h790000F0);
        wr(8'h1F, 1, 32'h00000008);
        rd(8'h1C, 4); chk("R7 clear bit 27", last_rd, 32'h710000F0);
        hw(5'd20, 32'hFFFFFFFF);
        rd(8'h50, 4); chk("R7 link status set", last_rd, 32'hC0000000);
        wr(8'h52, 2, 32'h00004000);
        rd(8'h50, 4); chk("R7 link status clear", last_rd, 32'h80000000);
        hw(5'd22, 32'hFFFFFFFF);
        rd(8'h58, 4); chk("R7 slot status set", last_rd, 32'h011F0000);
        hw(5'd18, 32'hFFFFFFFF);
        rd(8'h48, 4); chk("R7 device status set", last_rd, 32'h000F7FFF);
        wr(8'h4A, 1, 32'h00000005);
        rd(8'h48, 4); chk("R7 device status clear", last_rd, 32'h000A7FFF);

        // R8 set beats clear
        acc(8'h1C, 4, 1'b1, 32'hF9000000, 1'b1, 5'd7, 32'h80000000, 1'b1);
        rd(8'h1C, 4); chk("R8 set wins", last_rd, 32'h80000000);

        // R4 illegal sizes
        acc(8'h18, 3, 1'b1, 32'hFFFFFFFF, 1'b0, 5'd0, 32'h0, 1'b1);
        chk("R4 err flag", {31'd0, last_err}, 32'h1);
        rd(8'h18, 4); chk("R4 no state change", last_rd, 32'h0034AB00);
        rd(8'h18, 0); chk("R4 size 0 err", {31'd0, last_err}, 32'h1);
        chk("R4 size 0 data", last_rd, 32'h0);
        rd(8'h18, 7); chk("R4 size 7 err", {31'd0, last_err}, 32'h1);

        // R12 unimplemented space
        rd(8'h80, 4); chk("R12 read 0x80", last_rd, 32'h0);
        wr(8'h98, 4, 32'hFFFFFFFF);
        rd(8'h18, 4); chk("R12 no aliasing", last_rd, 32'h0034AB00);
        wr(8'h7C, 4, 32'hFFFFFFFF);
        rd(8'h7C, 4); chk("R12 read 0x7C", last_rd, 32'h0);

        // R11 variant without I/O forwarding
        rd(8'h04, 4); chk("R11 command io bit", last_nio, 32'h00100146);
        rd(8'h1C, 2); chk("R11 io window ro", last_nio, 32'h0000);
        wr(8'h30, 4, 32'hFFFFFFFF);
        rd(8'h30, 4);
        chk("R11 io upper ro", last_nio, 32'h0);
        chk("R10 io upper rw", last_rd, 32'hFFFFFFFF);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule